// File: doc/BRIEF.md
# Fusable Event Counter Bank

A bank of performance event counters. Each counter has a 64-bit control register and a 48-bit count register. Every clock, each counter can take an unsigned increment of up to 4 bits from its own event input. This lets a single counter follow an event that fires up to fifteen times per cycle. Some events fire more often than that. For those, an even counter and the odd counter directly above it can be fused into one counter. The fused counter takes an 8-bit increment per clock and holds a 64-bit count.

Software fuses a pair by writing a reserved merge event code, with the enable bit set, into the odd counter's control register. Only after that does it enable the even counter. While the pair is fused, the odd counter no longer counts its own events. Its 4-bit input becomes the high nibble of the even counter's increment, and the low 16 bits of its count register carry count bits 63:48. Writing zero to the odd control register splits the pair again. All registers go through one port that is addressed by counter index, with a select that picks the control or the count register. Reads are combinational. Writes take effect at the next clock edge.

Top module: `merge_ctr_bank`

## Requirements
- R1: After a synchronous active-low reset, every control and count register reads zero.
- R2: A counter whose control bit 22 is set adds its 4-bit input (lane i at evt_inc[4i+3:4i]) to its count every clock, wrapping modulo 2^48; with bit 22 clear the count holds.
- R3: An odd counter whose control register has bit 22 set, bits 35:32 equal to 0xF and bits 7:0 equal to 0xFF (the merge code) stops counting its own input, including while the even partner is disabled.
- R4: While its partner is merged, an enabled even counter adds the 8-bit value {odd input, even input} each clock to the 64-bit value {odd count[15:0], even count[47:0]}, with carry from bit 47 into bit 48 and wrap modulo 2^64.
- R5: In merged mode a read of the even count register (select 1) returns the full 64-bit count, and a write to it loads only the low 48 bits from wdata[47:0], leaving bits 63:48 unchanged.
- R6: In merged mode a write to the odd count register loads count bits 63:48 from wdata[15:0]. A later read of the odd count returns them zero-extended.
- R7: The merge code without bit 22 has no pairing effect. The even counter then counts only its own input, and the odd counter holds.
- R8: Writing zero to the odd control register breaks the pairing. The even counter then returns to 48-bit counting of its own input, and its reads are zero-extended.
- R9: The merge code written into an even counter's control register has no pairing effect. Both counters of that pair count their own inputs.
- R10: reg_sel 0 addresses the control register and 1 addresses the count register of counter reg_idx. A control write stores all 64 bits and reads back unchanged.
- R11: An unmerged count write loads wdata[47:0], and an unmerged count read returns the 48-bit count zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the count register |
| reg_idx | input | IDX_W (2) | Counter index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_idx/reg_sel |
| evt_inc | input | NUM_CTR*4 (16) | Per-counter increments, lane i at [4i+3:4i] |

## Verification
A register write or an increment shows up at reg_rdata after exactly one clock edge. The read path adds no latency. The bench changes inputs on the falling edge and leaves each increment in place for a known number of rising edges. It then zeroes the increment before any read, so the expected count is always the start value plus that edge count times the increment. Reads are sampled one nanosecond after the address is set, well clear of any rising edge. The fused mode is swept over all 256 pairs of input nibbles, starting just below the bit-48 carry.

// File: rtl/merge_ctr_pkg.sv
// Package: constants and helpers shared by the fusable counter bank.
// Assumes the control layout is 64 bits wide, with the enable bit and the merge code fields fixed.
package merge_ctr_pkg;
    localparam int CTL_W       = 64;
    localparam int EN_BIT      = 22;
    localparam logic [3:0] MERGE_HI = 4'hF;
    localparam logic [7:0] MERGE_LO = 8'hFF;

    // Register select encoding on the access port
    typedef enum logic {SEL_CTL = 1'b0, SEL_CNT = 1'b1} reg_sel_e;

    // True when a control word holds the enabled merge code
    function automatic logic is_merge(input logic en, input logic [3:0] hi, input logic [7:0] lo);
        return en && (hi == MERGE_HI) && (lo == MERGE_LO);
    endfunction
endpackage

// File: rtl/merge_ctr_pair.sv
// Module: one even/odd counter pair, with its control and count registers.
// Counts each lane alone, or fuses both lanes into one 64-bit counter when the
// odd control holds the enabled merge code. Assumes at most one register write per cycle.
// A write replaces only the update of the register it targets.
module merge_ctr_pair
    import merge_ctr_pkg::*;
#(
    parameter int INC_W  = 4,
    parameter int BASE_W = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_ctl_e,
    input  logic              we_ctl_o,
    input  logic              we_cnt_e,
    input  logic              we_cnt_o,
    input  logic [DATA_W-1:0] wdata,
    input  logic [INC_W-1:0]  inc_e,
    input  logic [INC_W-1:0]  inc_o,
    output logic [DATA_W-1:0] rd_ctl_e,
    output logic [DATA_W-1:0] rd_ctl_o,
    output logic [DATA_W-1:0] rd_cnt_e,
    output logic [DATA_W-1:0] rd_cnt_o
);
    localparam int HI_W   = DATA_W - BASE_W;
    localparam int WINC_W = 2 * INC_W;

    logic [CTL_W-1:0]  ctl_e, ctl_o;
    logic [BASE_W-1:0] cnt_e, cnt_o;
    logic [BASE_W-1:0] cnt_e_nxt, cnt_o_nxt;
    logic [DATA_W-1:0] wide_now, wide_sum;
    logic              en_e, en_o, merged;

    assign en_e     = ctl_e[EN_BIT];
    assign en_o     = ctl_o[EN_BIT];
    assign merged   = is_merge(en_o, ctl_o[35:32], ctl_o[7:0]);
    assign wide_now = {cnt_o[HI_W-1:0], cnt_e};
    assign wide_sum = wide_now + DATA_W'({inc_o, inc_e});

    // Control registers: stored whole on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_e <= '0;
            ctl_o <= '0;
        end else begin
            if (we_ctl_e) ctl_e <= wdata[CTL_W-1:0];
            if (we_ctl_o) ctl_o <= wdata[CTL_W-1:0];
        end
    end

    // Next even count: a write, a fused step, a lone step, or hold
    always_comb begin
        if (we_cnt_e)
            cnt_e_nxt = wdata[BASE_W-1:0];
        else if (en_e && merged)
            cnt_e_nxt = wide_sum[BASE_W-1:0];
        else if (en_e)
            cnt_e_nxt = cnt_e + BASE_W'(inc_e);
        else
            cnt_e_nxt = cnt_e;
    end

    // Next odd count: upper-part load and carry when fused, else a normal counter
    always_comb begin
        if (we_cnt_o)
            cnt_o_nxt = merged ? BASE_W'(wdata[HI_W-1:0]) : wdata[BASE_W-1:0];
        else if (merged)
            cnt_o_nxt = en_e ? {cnt_o[BASE_W-1:HI_W], wide_sum[DATA_W-1:BASE_W]} : cnt_o;
        else if (en_o)
            cnt_o_nxt = cnt_o + BASE_W'(inc_o);
        else
            cnt_o_nxt = cnt_o;
    end

    // Count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_e <= '0;
            cnt_o <= '0;
        end else begin
            cnt_e <= cnt_e_nxt;
            cnt_o <= cnt_o_nxt;
        end
    end

    // Read views: the even count shows the fused 64-bit value when merged
    always_comb begin
        rd_ctl_e = DATA_W'(ctl_e);
        rd_ctl_o = DATA_W'(ctl_o);
        rd_cnt_e = merged ? wide_now : DATA_W'(cnt_e);
        rd_cnt_o = DATA_W'(cnt_o);
    end

    // R3: a fused odd counter with its partner idle never moves by itself
    a_r3_odd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (merged && !en_e && !we_cnt_o) |=> $stable(cnt_o));

    // R4: a fused step adds the joined increment across the bit-48 boundary
    a_r4_fused_step: assert property (@(posedge clk) disable iff (!rst_n)
        (merged && en_e && !we_cnt_e && !we_cnt_o && !we_ctl_o) |=>
        ({cnt_o[HI_W-1:0], cnt_e} == $past(wide_now) + DATA_W'($past({inc_o, inc_e}))));

    // R5: an even count write loads exactly the low part
    a_r5_even_load: assert property (@(posedge clk) disable iff (!rst_n)
        we_cnt_e |=> (cnt_e == $past(wdata[BASE_W-1:0])));

    // R2: a disabled, unwritten even counter holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_e && !we_cnt_e && !we_ctl_e) |=> $stable(cnt_e));

    // R2: an unfused enabled odd counter steps by its own input
    a_r2_odd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!merged && en_o && !we_cnt_o && !we_ctl_o) |=>
        (cnt_o == $past(cnt_o) + BASE_W'($past(inc_o))));

    // Unused-width guard for the joined increment
    initial assert (WINC_W <= DATA_W);
endmodule

// File: rtl/merge_ctr_rdmux.sv
// Module: read multiplexer for the register port.
// Picks the control or count view of one counter. Purely combinational; assumes the index is in range.
module merge_ctr_rdmux
    import merge_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int DATA_W  = 64,
    localparam int IDX_W  = $clog2(NUM_CTR)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              sel,
    input  logic [DATA_W-1:0] ctl_view [NUM_CTR],
    input  logic [DATA_W-1:0] cnt_view [NUM_CTR],
    output logic [DATA_W-1:0] rdata
);
    // Select the addressed register view
    always_comb begin
        rdata = (reg_sel_e'(sel) == SEL_CNT) ? cnt_view[idx] : ctl_view[idx];
    end
endmodule

// File: rtl/merge_ctr_bank.sv
// Module: top of the fusable event counter bank.
// Builds NUM_CTR/2 counter pairs and one register port. Assumes NUM_CTR is even, a power of two and at least 2.
module merge_ctr_bank
    import merge_ctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int INC_W   = 4,
    parameter int BASE_W  = 48,
    parameter int DATA_W  = 64,
    localparam int IDX_W  = $clog2(NUM_CTR),
    localparam int NUM_PAIR = NUM_CTR / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic                     reg_sel,
    input  logic [IDX_W-1:0]         reg_idx,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_CTR*INC_W-1:0] evt_inc
);
    logic [DATA_W-1:0] ctl_view [NUM_CTR];
    logic [DATA_W-1:0] cnt_view [NUM_CTR];

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        localparam int EI = 2 * p;
        localparam int OI = 2 * p + 1;
        logic hit_e, hit_o;

        // Address decode for this pair
        always_comb begin
            hit_e = reg_we && (reg_idx == IDX_W'(EI));
            hit_o = reg_we && (reg_idx == IDX_W'(OI));
        end

        merge_ctr_pair #(
            .INC_W (INC_W),
            .BASE_W(BASE_W),
            .DATA_W(DATA_W)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_ctl_e(hit_e && (reg_sel_e'(reg_sel) == SEL_CTL)),
            .we_ctl_o(hit_o && (reg_sel_e'(reg_sel) == SEL_CTL)),
            .we_cnt_e(hit_e && (reg_sel_e'(reg_sel) == SEL_CNT)),
            .we_cnt_o(hit_o && (reg_sel_e'(reg_sel) == SEL_CNT)),
            .wdata   (reg_wdata),
            .inc_e   (evt_inc[EI*INC_W +: INC_W]),
            .inc_o   (evt_inc[OI*INC_W +: INC_W]),
            .rd_ctl_e(ctl_view[EI]),
            .rd_ctl_o(ctl_view[OI]),
            .rd_cnt_e(cnt_view[EI]),
            .rd_cnt_o(cnt_view[OI])
        );
    end

    merge_ctr_rdmux #(
        .NUM_CTR(NUM_CTR),
        .DATA_W (DATA_W)
    ) u_rdmux (
        .idx     (reg_idx),
        .sel     (reg_sel),
        .ctl_view(ctl_view),
        .cnt_view(cnt_view),
        .rdata   (reg_rdata)
    );

    // R1: the read port shows zero in the first cycle after reset
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0));
endmodule

// File: tb/sim_merge_ctr_bank.sv
// Bench: self-checking sweeps over a four-counter bank, with expected values computed arithmetically.
module sim_merge_ctr_bank;
    localparam logic [63:0] EN    = 64'h1 << 22;
    localparam logic [63:0] MCODE = (64'hF << 32) | 64'hFF;
    localparam logic [63:0] M48   = (64'h1 << 48) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [15:0] evt_inc = '0;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] exp_c [4];
    logic [63:0] got;

    always #10 clk = ~clk;

    merge_ctr_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_inc(evt_inc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input int idx, input logic sel, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 2'(idx); reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int idx, input logic sel, output logic [63:0] d);
        @(negedge clk);
        reg_idx = 2'(idx); reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic run(input logic [15:0] v, input int k);
        @(negedge clk);
        evt_inc = v;
        repeat (k) @(posedge clk);
        @(negedge clk);
        evt_inc = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [63:0] wide, base_lo;
        logic [3:0]  li [4];
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every register
        for (int i = 0; i < 4; i++) begin
            rd(i, 1'b0, got); chk("R1 ctl", got, 64'h0);
            rd(i, 1'b1, got); chk("R1 cnt", got, 64'h0);
        end

        // R10: control write/readback of all 64 bits
        wr(0, 1'b0, 64'hA5C3_0F1E_0000_1234);
        rd(0, 1'b0, got); chk("R10 ctl readback", got, 64'hA5C3_0F1E_0000_1234);

        // R2: all four counters independent, sweep of every nibble value
        for (int i = 0; i < 4; i++) begin
            wr(i, 1'b0, EN | 64'h0C);
            exp_c[i] = '0;
        end
        for (int v = 0; v < 16; v++) begin
            li[0] = 4'(v); li[1] = 4'(15 - v); li[2] = 4'((v * 7) % 16); li[3] = 4'((v + 3) % 16);
            run({li[3], li[2], li[1], li[0]}, 3);
            for (int i = 0; i < 4; i++) begin
                exp_c[i] = (exp_c[i] + 3 * 64'(li[i])) & M48;
                rd(i, 1'b1, got); chk("R2 lone count", got, exp_c[i]);
            end
        end

        // R2/R11: 48-bit wrap and zero-extended access
        wr(2, 1'b1, M48 - 2);
        run(16'h0500, 1);
        rd(2, 1'b1, got); chk("R2 wrap48", got, 64'h2);
        wr(3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(3, 1'b1, got); chk("R11 write low48", got, M48);

        // R2: a disabled counter holds
        wr(3, 1'b0, 64'h0C);
        run(16'hF000, 5);
        rd(3, 1'b1, got); chk("R2 disabled hold", got, M48);

        // R7: merge code without enable does not fuse
        wr(1, 1'b0, MCODE);
        wr(0, 1'b1, 64'h0);
        wr(1, 1'b1, 64'h55);
        run(16'h0092, 4);
        rd(0, 1'b1, got); chk("R7 even own only", got, 64'h8);
        rd(1, 1'b1, got); chk("R7 odd holds", got, 64'h55);

        // R3/R4/R5/R6: fused sweep over all 256 input pairs, starting near the carry
        wr(1, 1'b0, MCODE | EN);
        wr(0, 1'b0, EN | 64'h03);
        for (int o = 0; o < 16; o++) begin
            for (int e = 0; e < 16; e++) begin
                base_lo = M48 - 64'(o * 3 + e);
                wr(1, 1'b1, 64'hDEAD_BEEF_0000_1234);
                wr(0, 1'b1, base_lo);
                run(16'((o << 4) | e), 2);
                wide = {16'h1234, base_lo[47:0]} + 2 * 64'((o << 4) | e);
                rd(0, 1'b1, got); chk("R4 fused count", got, wide);
                rd(1, 1'b1, got); chk("R6 odd upper", got, {48'h0, wide[63:48]});
            end
        end

        // R4: wrap at 2^64
        wr(1, 1'b1, 64'hFFFF);
        wr(0, 1'b1, M48);
        run(16'h0001, 1);
        rd(0, 1'b1, got); chk("R4 wrap64", got, 64'h0);

        // R5: even write loads low 48 only, upper part kept
        wr(1, 1'b1, 64'h00AB);
        wr(0, 1'b0, MCODE & 64'h0);
        wr(0, 1'b1, 64'h7777_0000_0000_0042);
        rd(0, 1'b1, got); chk("R5 even write keeps upper", got, 64'h00AB_0000_0000_0042);

        // R3: partner idle, fused odd does not count its own input
        run(16'h00F0, 6);
        rd(1, 1'b1, got); chk("R3 odd frozen", got, 64'h00AB);
        rd(0, 1'b1, got); chk("R3 even idle", got, 64'h00AB_0000_0000_0042);

        // R8: zero in odd control splits the pair
        wr(0, 1'b0, EN);
        wr(1, 1'b0, 64'h0);
        run(16'h0073, 4);
        rd(0, 1'b1, got); chk("R8 split even", got, 64'h42 + 64'd12);
        rd(1, 1'b1, got); chk("R8 split odd holds", got, 64'h00AB);

        // R9: merge code in an even control does not fuse
        wr(2, 1'b1, 64'h0);
        wr(3, 1'b1, 64'h0);
        wr(2, 1'b0, MCODE | EN);
        wr(3, 1'b0, EN);
        run(16'h9500, 3);
        rd(2, 1'b1, got); chk("R9 even own", got, 64'd15);
        rd(3, 1'b1, got); chk("R9 odd own", got, 64'd27);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule